// File: doc/BRIEF.md
# SPI Master Word Buffer

This block is the buffering layer between a processor's byte-wide register port and a simple SPI shift engine. Software writes a 16-bit word as two bytes: the high byte goes into a holding register and the low byte commits the whole word to a one-deep transmit slot. The buffer hands the slot to the shift engine as soon as the engine is idle. A transmit-empty status bit tells software when the slot is free again.

On the receive side, every frame the engine completes is offered to a readable 16-bit data register guarded by a receive-full flag. Software services the flag by reading the status register while the flag is set and then reading the low data byte. If a frame completes while the flag is still set, it is parked in a one-deep shadow and is not written over the data register. Servicing the flag before another transfer starts promotes the parked frame and keeps the flag set. If a new transfer starts first, the parked frame is discarded and an overrun-lost status bit records the loss.

Top module: `spi_word_buffer`

## Requirements
- R1: After reset, both data bytes read 0x00 and the status byte reads 0x20: receive-full (bit 7) clear, transmit-empty (bit 5) set, and overrun-lost (bit 0) clear.
- R2: A write to offset 4 stores the high byte in a holding register. A write to offset 5 queues the word {held high byte, written low byte} and clears transmit-empty. A new low-byte write while a word is still queued replaces that word.
- R3: A queued word is driven on `eng_txword` with a one-cycle `eng_start` pulse at the first clock edge where no transfer is in flight and `eng_busy` is low. A transfer counts as in flight from its start until `eng_done`. Transmit-empty is set at that edge unless a low-byte write lands in the same cycle.
- R4: Reads are combinational. Offset 3 returns the status byte {full, 0, tx-empty, 0000, lost}. Offset 4 returns data[15:8], offset 5 returns data[7:0], and every other offset returns 0x00.
- R5: When `eng_done` pulses and receive-full is clear, `eng_rxword` is loaded into the data register and receive-full is set.
- R6: When `eng_done` pulses and receive-full is set, the data register keeps its value and the new frame is parked.
- R7: A service is a read of offset 5 after a status read that saw receive-full set. If a parked frame is valid at the service, the parked frame moves into the data register and receive-full stays set.
- R8: A service with no parked frame clears receive-full.
- R9: A read of offset 5 that does not follow a status read with receive-full set leaves both receive-full and the data register unchanged.
- R10: An `eng_start` issued while a parked frame is valid discards that frame, so it never reaches the data register, and sets overrun-lost.
- R11: A status read clears overrun-lost, unless a frame is discarded in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | BYTE_W | Write byte |
| reg_rdata | output | BYTE_W | Read byte, combinational from the offset |
| eng_start | output | 1 | One-cycle transfer start pulse |
| eng_txword | output | 2*BYTE_W | Word for the transfer being started |
| eng_busy | input | 1 | Shift engine busy level |
| eng_done | input | 1 | One-cycle frame-complete pulse |
| eng_rxword | input | 2*BYTE_W | Received frame, valid with `eng_done` |

## Verification
The hardest situation to reach is a parked frame whose fate depends on the order of a flag service and the next transfer start. Reaching it takes two completed frames with no service in between. The bench first lets two frames land unserviced and then services before queueing anything more, which must promote the parked frame with the flag held. It then repeats the setup but queues a third word before servicing, so the parked frame must be lost and the lost bit must show on the next status read. A behavioural reference model, kept in queues, follows every clock so that start timing and overwrite-while-queued are checked continuously.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;
  localparam int BYTE_W_DEF = 8;
  localparam int ADDR_W_DEF = 3;

  // register offsets
  localparam int OFS_STAT = 3;
  localparam int OFS_DHI  = 4;
  localparam int OFS_DLO  = 5;

  // status bit positions
  localparam int ST_FULL = 7;
  localparam int ST_TXE  = 5;
  localparam int ST_LOST = 0;

  typedef struct packed {
    logic wr_hi;
    logic wr_lo;
    logic rd_stat;
    logic rd_lo;
  } acc_t;
endpackage

// File: rtl/spi_wb_rst_sync.sv
module spi_wb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/spi_wb_regif.sv
module spi_wb_regif
  import spi_wb_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int BYTE_W = BYTE_W_DEF,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              lost,
  output acc_t              acc,
  output logic [BYTE_W-1:0] rdata
);
  logic is_stat, is_hi, is_lo;
  logic [BYTE_W-1:0] stat_byte;

  always_comb begin
    is_stat = (addr == ADDR_W'(OFS_STAT));
    is_hi   = (addr == ADDR_W'(OFS_DHI));
    is_lo   = (addr == ADDR_W'(OFS_DLO));

    acc.wr_hi   = wr & is_hi;
    acc.wr_lo   = wr & is_lo;
    acc.rd_stat = rd & is_stat;
    acc.rd_lo   = rd & is_lo;

    stat_byte          = '0;
    stat_byte[ST_FULL] = rx_full;
    stat_byte[ST_TXE]  = tx_empty;
    stat_byte[ST_LOST] = lost;

    rdata = '0;
    if (is_stat)    rdata = stat_byte;
    else if (is_hi) rdata = rx_data[WORD_W-1:BYTE_W];
    else if (is_lo) rdata = rx_data[BYTE_W-1:0];
  end
endmodule

// File: rtl/spi_wb_tx.sv
module spi_wb_tx #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              eng_busy,
  input  logic              eng_done,
  output logic              launch,
  output logic              tx_empty,
  output logic              eng_start,
  output logic [WORD_W-1:0] eng_txword
);
  logic [BYTE_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              full_q, full_d;
  logic              fly_q, fly_d;
  logic              start_q, start_d;
  logic [WORD_W-1:0] txw_q, txw_d;

  always_comb begin
    launch = full_q & ~fly_q & ~eng_busy;

    hold_d = hold_q;
    if (wr_hi) hold_d = wdata;

    word_d = word_q;
    full_d = full_q;
    if (launch) full_d = 1'b0;
    if (wr_lo) begin
      word_d = {hold_q, wdata};
      full_d = 1'b1;
    end

    fly_d = fly_q;
    if (eng_done) fly_d = 1'b0;
    if (launch)   fly_d = 1'b1;

    start_d = launch;
    txw_d   = launch ? word_q : txw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      word_q  <= '0;
      full_q  <= 1'b0;
      fly_q   <= 1'b0;
      start_q <= 1'b0;
      txw_q   <= '0;
    end else begin
      hold_q  <= hold_d;
      word_q  <= word_d;
      full_q  <= full_d;
      fly_q   <= fly_d;
      start_q <= start_d;
      txw_q   <= txw_d;
    end
  end

  assign tx_empty   = ~full_q;
  assign eng_start  = start_q;
  assign eng_txword = txw_q;
endmodule

// File: rtl/spi_wb_rx.sv
module spi_wb_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rxword,
  input  logic              rd_stat,
  input  logic              rd_lo,
  input  logic              launch,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_full,
  output logic              lost,
  output logic              park_vld,
  output logic              service
);
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] park_q, park_d;
  logic              full_q, full_d;
  logic              pv_q, pv_d;
  logic              armed_q, armed_d;
  logic              lost_q, lost_d;
  logic              drop, promote;

  always_comb begin
    service = rd_lo & armed_q;
    drop    = launch & pv_q;
    promote = service & pv_q & ~launch;

    armed_d = armed_q;
    if (rd_stat) armed_d = full_q;
    if (service) armed_d = 1'b0;

    data_d = data_q;
    full_d = full_q;
    park_d = park_q;
    pv_d   = pv_q;
    lost_d = lost_q;

    if (rd_stat) lost_d = 1'b0;
    if (drop) begin
      pv_d   = 1'b0;
      lost_d = 1'b1;
    end
    if (service) begin
      if (promote) begin
        data_d = park_q;
        pv_d   = 1'b0;
      end else begin
        full_d = 1'b0;
      end
    end
    if (eng_done) begin
      if (!full_d) begin
        data_d = eng_rxword;
        full_d = 1'b1;
      end else begin
        park_d = eng_rxword;
        pv_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      park_q  <= '0;
      full_q  <= 1'b0;
      pv_q    <= 1'b0;
      armed_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      park_q  <= park_d;
      full_q  <= full_d;
      pv_q    <= pv_d;
      armed_q <= armed_d;
      lost_q  <= lost_d;
    end
  end

  assign rx_data  = data_q;
  assign rx_full  = full_q;
  assign lost     = lost_q;
  assign park_vld = pv_q;
endmodule

// File: rtl/spi_word_buffer.sv
module spi_word_buffer
  import spi_wb_pkg::*;
#(
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int BYTE_W      = BYTE_W_DEF,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              eng_start,
  output logic [WORD_W-1:0] eng_txword,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] eng_rxword
);
  logic              rst_n_s;
  acc_t              acc;
  logic              launch;
  logic              tx_empty;
  logic [WORD_W-1:0] rx_data;
  logic              rx_full;
  logic              lost;
  logic              park_vld;
  logic              service;

  spi_wb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  spi_wb_regif #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regif (
    .rd       (reg_rd),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .lost     (lost),
    .acc      (acc),
    .rdata    (reg_rdata)
  );

  spi_wb_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_hi      (acc.wr_hi),
    .wr_lo      (acc.wr_lo),
    .wdata      (reg_wdata),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .launch     (launch),
    .tx_empty   (tx_empty),
    .eng_start  (eng_start),
    .eng_txword (eng_txword)
  );

  spi_wb_rx #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .eng_done   (eng_done),
    .eng_rxword (eng_rxword),
    .rd_stat    (acc.rd_stat),
    .rd_lo      (acc.rd_lo),
    .launch     (launch),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .lost       (lost),
    .park_vld   (park_vld),
    .service    (service)
  );
endmodule

// File: rtl/spi_word_buffer_chk.sv
module spi_word_buffer_chk
  import spi_wb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic              eng_start,
  input logic              eng_done,
  input logic              launch,
  input logic              tx_empty,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_full,
  input logic              lost,
  input logic              park_vld,
  input logic              service
);
  a_r2_write_queues: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == ADDR_W'(OFS_DLO)) |=> !tx_empty);

  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_start |=> !eng_start);

  a_r5_full_after_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_done |=> rx_full);

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_full && !service) |=> $stable(rx_data));

  a_r8_service_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (service && !park_vld && !eng_done) |=> !rx_full);

  a_r10_drop_sets_lost: assert property (@(posedge clk) disable iff (!rst_n_s)
    (launch && park_vld) |=> (lost && !park_vld));

  a_r11_lost_clears: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd && reg_addr == ADDR_W'(OFS_STAT) && !(launch && park_vld)) |=> !lost);
endmodule

bind spi_word_buffer spi_word_buffer_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .reg_addr  (reg_addr),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .eng_start (eng_start),
  .eng_done  (eng_done),
  .launch    (launch),
  .tx_empty  (tx_empty),
  .rx_data   (rx_data),
  .rx_full   (rx_full),
  .lost      (lost),
  .park_vld  (park_vld),
  .service   (service)
);

// File: tb/spi_word_buffer_tb.sv
module spi_word_buffer_tb;
  localparam int AW  = 3;
  localparam int BW  = 8;
  localparam int WW  = 16;
  localparam int LEN = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] reg_addr;
  logic          reg_rd, reg_wr;
  logic [BW-1:0] reg_wdata, reg_rdata;
  logic          eng_start;
  logic [WW-1:0] eng_txword;
  logic          eng_busy, eng_done;
  logic [WW-1:0] eng_rxword;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_word_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_start(eng_start), .eng_txword(eng_txword), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_rxword(eng_rxword)
  );

  // shift engine model
  int            cnt;
  int            frames;
  logic [WW-1:0] last_tx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_busy <= 1'b0; eng_done <= 1'b0; eng_rxword <= '0;
      cnt <= 0; frames <= 0; last_tx <= '0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        eng_busy <= 1'b1; cnt <= LEN; last_tx <= eng_txword;
      end else if (cnt > 0) begin
        if (cnt == 1) begin
          eng_busy   <= 1'b0;
          eng_done   <= 1'b1;
          eng_rxword <= 16'hC000 + 16'(frames);
          frames     <= frames + 1;
        end
        cnt <= cnt - 1;
      end
    end
  end

  // behavioural reference model
  logic [7:0]  m_hold;
  logic [15:0] m_txq[$];
  logic [15:0] m_park[$];
  logic [15:0] m_txw, m_data;
  bit          m_fly, m_start, m_full, m_armed, m_lost;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = '0; m_txq.delete(); m_park.delete(); m_txw = '0; m_data = '0;
      m_fly = 0; m_start = 0; m_full = 0; m_armed = 0; m_lost = 0;
    end else begin
      bit launch, drop, svc, full_old;
      full_old = m_full;
      launch = (m_txq.size() != 0) && !m_fly && !eng_busy;
      drop   = launch && (m_park.size() != 0);
      svc    = reg_rd && reg_addr == 3'd5 && m_armed;
      m_start = launch;
      if (launch) m_txw = m_txq.pop_front();
      if (eng_done) m_fly = 0;
      if (launch) m_fly = 1;
      if (reg_wr && reg_addr == 3'd5) begin
        m_txq.delete(); m_txq.push_back({m_hold, reg_wdata});
      end
      if (reg_wr && reg_addr == 3'd4) m_hold = reg_wdata;
      if (reg_rd && reg_addr == 3'd3) begin m_lost = 0; m_armed = full_old; end
      if (drop) begin m_park.delete(); m_lost = 1; end
      if (svc) begin
        if (m_park.size() != 0) m_data = m_park.pop_front();
        else m_full = 0;
        m_armed = 0;
      end
      if (eng_done) begin
        if (!m_full) begin m_data = eng_rxword; m_full = 1; end
        else begin m_park.delete(); m_park.push_back(eng_rxword); end
      end
    end
  end

  function automatic logic [7:0] mexp(input logic [2:0] a);
    case (a)
      3'd3:    return {m_full, 1'b0, m_txq.size() == 0, 4'b0, m_lost};
      3'd4:    return m_data[15:8];
      3'd5:    return m_data[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle compare of the engine side (R3)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 start", 32'(eng_start), 32'(m_start));
      if (m_start) chk("R3 txword", 32'(eng_txword), 32'(m_txw));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    #2;
    chk({tag, " model"}, 32'(reg_rdata), 32'(mexp(a)));
    chk(tag, 32'(reg_rdata), 32'(exp));
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state, R4 offset map
    rd(3'd3, 8'h20, "R1 status");
    rd(3'd4, 8'h00, "R1 data hi");
    rd(3'd5, 8'h00, "R1 data lo");
    rd(3'd0, 8'h00, "R4 unmapped");

    // R2 queue, R3 launch, R5 load, R7/R8 service
    wr(3'd4, 8'h12);
    wr(3'd5, 8'h34);
    rd(3'd3, 8'h00, "R2 tx-empty cleared");
    idle(14);
    chk("R3 word sent", 32'(last_tx), 32'h1234);
    rd(3'd3, 8'hA0, "R5 full set");
    rd(3'd4, 8'hC0, "R4 data hi");
    rd(3'd5, 8'h00, "R5 data lo");
    rd(3'd3, 8'h20, "R8 full cleared");

    // R9 unarmed data read
    wr(3'd4, 8'hAB);
    wr(3'd5, 8'hCD);
    idle(14);
    rd(3'd5, 8'h01, "R9 unarmed read");
    rd(3'd3, 8'hA0, "R9 still full");
    rd(3'd5, 8'h01, "R9 service read");
    rd(3'd3, 8'h20, "R8 cleared");

    // service before third transfer: R6, R7
    wr(3'd4, 8'h11); wr(3'd5, 8'h22);
    idle(14);
    wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    idle(14);
    rd(3'd5, 8'h02, "R6 data kept");
    rd(3'd4, 8'hC0, "R6 data hi");
    rd(3'd3, 8'hA0, "R6 full");
    rd(3'd5, 8'h02, "R7 service read");
    rd(3'd3, 8'hA0, "R7 full stays");
    rd(3'd5, 8'h03, "R7 promoted");
    rd(3'd3, 8'h20, "R10 no loss");

    // back-to-back, overwrite while queued, then service after third: R2, R10, R11
    wr(3'd4, 8'h01); wr(3'd5, 8'h02);
    wr(3'd4, 8'h55); wr(3'd5, 8'h55);
    wr(3'd4, 8'h66); wr(3'd5, 8'h66);
    idle(24);
    chk("R2 overwrite", 32'(last_tx), 32'h6666);
    rd(3'd5, 8'h04, "R6 parked unseen");
    wr(3'd4, 8'h77); wr(3'd5, 8'h77);
    idle(14);
    rd(3'd3, 8'hA1, "R10 lost set");
    rd(3'd5, 8'h04, "R10 data kept");
    rd(3'd3, 8'hA0, "R11 lost cleared");
    rd(3'd5, 8'h06, "R10 discarded frame skipped");
    rd(3'd3, 8'h20, "R8 final");
    idle(4);
    finish_run();
  end
endmodule